// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block scans a key matrix of up to eight rows by eight columns. It drives one row line low at a time and reads the column lines, which are pulled up and read low through a closed key. After each complete pass over the rows it forms one scan result: whether any key is down, the code of the key it reports, and whether more than one key is down. That result must stay unchanged for a programmable number of clock cycles before it is accepted. Accepted presses are reported as a 6-bit key code with a one-cycle valid strobe and a sticky interrupt request.

Two counting modes are available. In press-release-press mode each new press is one event, and a held key produces nothing more. In press-hold mode a held key is re-examined at a fixed programmable period, and each period it is still down yields another event carrying an incremented repeat count. When several keys are down together, a multi-key flag is raised and only the first key in row-then-column order is reported.

The row scanner is a three-state machine. SC_SETTLE drives the current row and counts settle cycles, and moves to SC_SAMPLE when the count reaches the settle setting. SC_SAMPLE reads the columns for one cycle. It then returns to SC_SETTLE for the next row, or moves to SC_REPORT after the last active row. SC_REPORT releases all rows for one cycle, publishes the scan result and returns to SC_SETTLE on row 0. The event stage is a two-state machine. EV_UP moves to EV_DOWN on an accepted press. EV_DOWN moves back to EV_UP on an accepted release. EV_DOWN stays in EV_DOWN on a repeat tick, and also on a press whose code differs from the last one reported.

Top module: `keypad_scan`

## Requirements
- R1: At most one row line is low at any time. Rows are driven in ascending order from row 0. Each row is held for cfg_settle+1 cycles and its columns are sampled in the following cycle. A full scan takes cfg_rows*(cfg_settle+2)+1 cycles, and its last cycle has every row line high.
- R2: Row lines with an index at or above cfg_rows are never driven low. Column inputs with an index at or above cfg_cols are ignored, so a closed key in such a column produces no event.
- R3: A change in the scan result (key down, reported code, multi-key) is accepted only after it has stayed unchanged for cfg_debounce cycles, counted from the scan that first showed it. A closure shorter than one scan period, with cfg_debounce larger than the scan period, produces no event.
- R4: key_code holds the row index in bits [5:3] and the column index in bits [2:0]. key_valid is high for exactly the one cycle after a press is accepted.
- R5: irq rises together with every key_valid and then stays high until irq_clear is sampled high. A new event in the same cycle as irq_clear keeps irq high.
- R6: With cfg_hold_mode = 0, pressing, releasing and pressing the same key again gives two events with the same code. A key held down gives no further events, and key_repeat stays 0.
- R7: With cfg_hold_mode = 1, while the accepted key stays down, a further key_valid with the same code occurs every cfg_hold_period+1 cycles, and key_repeat increases by one each time, saturating at its maximum.
- R8: An accepted release, which requires every key to read released for the full debounce width, sets key_repeat back to 0 and re-arms press detection.
- R9: When two or more keys are down in one scan, multi_key goes high once that result is accepted, and key_code reports the lowest row and, within it, the lowest column. multi_key falls on the accepted release.
- R10: While rst is high, row 0 is driven and key_valid, irq, multi_key, key_repeat and key_code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rows | input | 4 | Number of active rows, 1 to 8 |
| cfg_cols | input | 4 | Number of active columns, 1 to 8 |
| cfg_settle | input | 8 | Extra cycles a row is driven before sampling |
| cfg_debounce | input | 8 | Debounce width in cycles |
| cfg_hold_mode | input | 1 | 0 press-release-press, 1 press-hold repeat |
| cfg_hold_period | input | 16 | Repeat interval minus one, in cycles |
| irq_clear | input | 1 | Clears the pending interrupt |
| col_sense_n | input | 8 | Column inputs, low when a key in the driven row is closed |
| row_drv_n | output | 8 | Row outputs, low on the row being scanned |
| key_valid | output | 1 | One-cycle strobe for each reported event |
| key_code | output | 6 | Row in [5:3], column in [2:0] |
| key_repeat | output | 8 | Repeat count of the held key |
| multi_key | output | 1 | More than one key down in the accepted result |
| irq | output | 1 | Pending interrupt request |

## Verification
The assertions assume that the configuration inputs change only while rst is high, that cfg_rows and cfg_cols lie between 1 and 8, and that cfg_hold_period is at least 1, so a repeat strobe never lands on back-to-back cycles. The stimulus changes configuration only inside reset pulses and uses several settings within those ranges, including 8 rows with no settle cycles. Keys are opened and closed only on the falling clock edge, and the column lines are formed from the key matrix and the row outputs exactly as a passive keypad would form them.

// File: rtl/keypad_pkg.sv
package keypad_pkg;
    typedef enum logic [1:0] {
        SC_SETTLE,
        SC_SAMPLE,
        SC_REPORT
    } scan_state_e;

    typedef enum logic {
        EV_UP,
        EV_DOWN
    } key_state_e;
endpackage

// File: rtl/kp_row_scanner.sv
module kp_row_scanner
    import keypad_pkg::*;
#(
    parameter int MAX_ROWS = 8,
    parameter int MAX_COLS = 8,
    parameter int SETTLE_W = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [$clog2(MAX_ROWS+1)-1:0]     cfg_rows,
    input  logic [$clog2(MAX_COLS+1)-1:0]     cfg_cols,
    input  logic [SETTLE_W-1:0]               cfg_settle,
    input  logic [MAX_COLS-1:0]               col_sense_n,
    output logic [MAX_ROWS-1:0]               row_drv_n,
    output logic                              scan_done,
    output logic                              scan_down,
    output logic                              scan_multi,
    output logic [$clog2(MAX_ROWS)+$clog2(MAX_COLS)-1:0] scan_code
);
    localparam int ROW_W  = $clog2(MAX_ROWS);
    localparam int COL_W  = $clog2(MAX_COLS);
    localparam int RCNT_W = $clog2(MAX_ROWS+1);
    localparam int CCNT_W = $clog2(MAX_COLS+1);

    scan_state_e state_q, state_d;
    logic [ROW_W-1:0]    row_q;
    logic [SETTLE_W-1:0] settle_q;
    logic                any_q, multi_q;
    logic [ROW_W+COL_W-1:0] code_q;
    logic [MAX_COLS-1:0] col_mask, pressed;
    logic [MAX_ROWS-1:0] row_mask;
    logic [COL_W-1:0]    low_col;
    int                  npress;
    logic                last_row;

    for (genvar c = 0; c < MAX_COLS; c++) begin : g_colmask
        assign col_mask[c] = cfg_cols > CCNT_W'(c);
    end
    for (genvar r = 0; r < MAX_ROWS; r++) begin : g_rowmask
        assign row_mask[r] = cfg_rows > RCNT_W'(r);
    end

    assign pressed  = ~col_sense_n & col_mask;
    assign last_row = (row_q == ROW_W'(cfg_rows - 1'b1));

    always_comb begin
        low_col = '0;
        for (int c = MAX_COLS - 1; c >= 0; c--) begin
            if (pressed[c]) low_col = COL_W'(c);
        end
        npress = $countones(pressed);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_SETTLE: if (settle_q == cfg_settle) state_d = SC_SAMPLE;
            SC_SAMPLE: state_d = last_row ? SC_REPORT : SC_SETTLE;
            SC_REPORT: state_d = SC_SETTLE;
            default:   state_d = SC_SETTLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SC_SETTLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q    <= '0;
            settle_q <= '0;
            any_q    <= 1'b0;
            multi_q  <= 1'b0;
            code_q   <= '0;
        end else begin
            unique case (state_q)
                SC_SETTLE: if (settle_q != cfg_settle) settle_q <= settle_q + 1'b1;
                SC_SAMPLE: begin
                    settle_q <= '0;
                    if (|pressed) begin
                        if (any_q || npress > 1) multi_q <= 1'b1;
                        if (!any_q) code_q <= {row_q, low_col};
                        any_q <= 1'b1;
                    end
                    if (!last_row) row_q <= row_q + 1'b1;
                end
                SC_REPORT: begin
                    row_q   <= '0;
                    any_q   <= 1'b0;
                    multi_q <= 1'b0;
                    code_q  <= '0;
                end
                default: row_q <= '0;
            endcase
        end
    end

    always_comb begin
        row_drv_n = '1;
        if (state_q != SC_REPORT) row_drv_n[row_q] = 1'b0;
        scan_done  = (state_q == SC_REPORT);
        scan_down  = any_q;
        scan_multi = multi_q;
        scan_code  = code_q;
    end

    AST_ONE_ROW_LOW: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~row_drv_n)); // R1
    AST_UNUSED_ROW_IDLE: assert property (@(posedge clk) disable iff (rst)
        (~row_drv_n & ~row_mask) == '0); // R2
    AST_ROW_SETTLED: assert property (@(posedge clk) disable iff (rst)
        state_q == SC_SAMPLE |-> $stable(row_drv_n)); // R1
    AST_MULTI_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        scan_done && scan_multi |-> scan_down); // R9
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce #(
    parameter int DEB_W  = 8,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEB_W-1:0]  cfg_debounce,
    input  logic              scan_done,
    input  logic              scan_down,
    input  logic              scan_multi,
    input  logic [CODE_W-1:0] scan_code,
    output logic              accept,
    output logic              cand_down,
    output logic [CODE_W-1:0] cand_code,
    output logic              acc_multi
);
    localparam int VEC_W = CODE_W + 2;

    logic [VEC_W-1:0] cand_q, acc_q, scan_vec;
    logic [DEB_W-1:0] cnt_q;

    assign scan_vec  = {scan_down, scan_multi, scan_code};
    assign accept    = (cnt_q == cfg_debounce) && (cand_q != acc_q);
    assign cand_down = cand_q[VEC_W-1];
    assign cand_code = cand_q[CODE_W-1:0];
    assign acc_multi = acc_q[CODE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= '0;
            acc_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (scan_done && scan_vec != cand_q) begin
                cand_q <= scan_vec;
                cnt_q  <= '0;
            end else if (cnt_q != cfg_debounce) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (accept) acc_q <= cand_q;
        end
    end

    AST_ACCEPT_FROM_CAND: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc_q) |-> acc_q == $past(cand_q)); // R3
    AST_CAND_FRESH_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        cfg_debounce != '0 && scan_done && scan_vec != cand_q |=> !accept); // R3
endmodule

// File: rtl/kp_event.sv
module kp_event
    import keypad_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int HOLD_W = 16,
    parameter int REP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_hold_mode,
    input  logic [HOLD_W-1:0] cfg_hold_period,
    input  logic              irq_clear,
    input  logic              accept,
    input  logic              cand_down,
    input  logic [CODE_W-1:0] cand_code,
    output logic              key_valid,
    output logic [CODE_W-1:0] key_code,
    output logic [REP_W-1:0]  key_repeat,
    output logic              irq
);
    key_state_e state_q;
    logic [HOLD_W-1:0] hold_q;
    logic              press, release_k, tick, fire;

    always_comb begin
        press     = accept && cand_down && (state_q == EV_UP || cand_code != key_code);
        release_k = accept && !cand_down && state_q == EV_DOWN;
        tick      = !press && !release_k && state_q == EV_DOWN && cfg_hold_mode
                    && hold_q == cfg_hold_period;
        fire      = press || tick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EV_UP;
        end else begin
            unique case (state_q)
                EV_UP:   if (press) state_q <= EV_DOWN;
                EV_DOWN: if (release_k) state_q <= EV_UP;
                default: state_q <= EV_UP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_valid  <= 1'b0;
            key_code   <= '0;
            key_repeat <= '0;
            hold_q     <= '0;
            irq        <= 1'b0;
        end else begin
            key_valid <= fire;
            irq       <= fire || (irq && !irq_clear);
            if (press) begin
                key_code   <= cand_code;
                key_repeat <= '0;
                hold_q     <= '0;
            end else if (release_k) begin
                key_repeat <= '0;
                hold_q     <= '0;
            end else if (state_q == EV_DOWN && cfg_hold_mode) begin
                if (tick) begin
                    hold_q <= '0;
                    if (key_repeat != '1) key_repeat <= key_repeat + 1'b1;
                end else begin
                    hold_q <= hold_q + 1'b1;
                end
            end
        end
    end

    AST_IRQ_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> irq); // R5
    AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq && !irq_clear |=> irq); // R5
    AST_PRP_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        key_valid && !cfg_hold_mode |-> key_repeat == '0); // R6
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        release_k |=> key_repeat == '0); // R8
endmodule

// File: rtl/keypad_scan.sv
module keypad_scan #(
    parameter int MAX_ROWS = 8,
    parameter int MAX_COLS = 8,
    parameter int SETTLE_W = 8,
    parameter int DEB_W    = 8,
    parameter int HOLD_W   = 16,
    parameter int REP_W    = 8
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic [$clog2(MAX_ROWS+1)-1:0]             cfg_rows,
    input  logic [$clog2(MAX_COLS+1)-1:0]             cfg_cols,
    input  logic [SETTLE_W-1:0]                       cfg_settle,
    input  logic [DEB_W-1:0]                          cfg_debounce,
    input  logic                                      cfg_hold_mode,
    input  logic [HOLD_W-1:0]                         cfg_hold_period,
    input  logic                                      irq_clear,
    input  logic [MAX_COLS-1:0]                       col_sense_n,
    output logic [MAX_ROWS-1:0]                       row_drv_n,
    output logic                                      key_valid,
    output logic [$clog2(MAX_ROWS)+$clog2(MAX_COLS)-1:0] key_code,
    output logic [REP_W-1:0]                          key_repeat,
    output logic                                      multi_key,
    output logic                                      irq
);
    localparam int CODE_W = $clog2(MAX_ROWS) + $clog2(MAX_COLS);

    logic              scan_done, scan_down, scan_multi;
    logic [CODE_W-1:0] scan_code, cand_code;
    logic              accept, cand_down;

    kp_row_scanner #(
        .MAX_ROWS(MAX_ROWS), .MAX_COLS(MAX_COLS), .SETTLE_W(SETTLE_W)
    ) i_scanner (
        .clk(clk), .rst(rst), .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
        .cfg_settle(cfg_settle), .col_sense_n(col_sense_n), .row_drv_n(row_drv_n),
        .scan_done(scan_done), .scan_down(scan_down), .scan_multi(scan_multi),
        .scan_code(scan_code)
    );

    kp_debounce #(.DEB_W(DEB_W), .CODE_W(CODE_W)) i_debounce (
        .clk(clk), .rst(rst), .cfg_debounce(cfg_debounce), .scan_done(scan_done),
        .scan_down(scan_down), .scan_multi(scan_multi), .scan_code(scan_code),
        .accept(accept), .cand_down(cand_down), .cand_code(cand_code),
        .acc_multi(multi_key)
    );

    kp_event #(.CODE_W(CODE_W), .HOLD_W(HOLD_W), .REP_W(REP_W)) i_event (
        .clk(clk), .rst(rst), .cfg_hold_mode(cfg_hold_mode),
        .cfg_hold_period(cfg_hold_period), .irq_clear(irq_clear), .accept(accept),
        .cand_down(cand_down), .cand_code(cand_code), .key_valid(key_valid),
        .key_code(key_code), .key_repeat(key_repeat), .irq(irq)
    );
endmodule

// File: tb/test_keypad_scan.sv
`timescale 1ns/1ps
module test_keypad_scan;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cfg_rows = 4'd4, cfg_cols = 4'd4;
    logic [7:0] cfg_settle = 8'd2, cfg_debounce = 8'd20;
    logic       cfg_hold_mode = 1'b0;
    logic [15:0] cfg_hold_period = 16'd50;
    logic       irq_clear = 1'b0;
    logic [7:0] col_sense_n, row_drv_n;
    logic       key_valid, multi_key, irq;
    logic [5:0] key_code;
    logic [7:0] key_repeat;
    logic [7:0] keys [8];

    int cyc = 0, cmp_n = 0, cmp_f = 0, sc_n = 0, sc_f = 0, ev_total = 0;

    always #4 clk = ~clk;

    keypad_scan i_keypad_scan (
        .clk(clk), .rst(rst), .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
        .cfg_settle(cfg_settle), .cfg_debounce(cfg_debounce),
        .cfg_hold_mode(cfg_hold_mode), .cfg_hold_period(cfg_hold_period),
        .irq_clear(irq_clear), .col_sense_n(col_sense_n), .row_drv_n(row_drv_n),
        .key_valid(key_valid), .key_code(key_code), .key_repeat(key_repeat),
        .multi_key(multi_key), .irq(irq)
    );

    // passive keypad: a closed key pulls its column low while its row is driven
    always_comb begin
        col_sense_n = '1;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                if (keys[r][c] && !row_drv_n[r]) col_sense_n[c] = 1'b0;
    end

    // behavioural reference model, advanced on every rising edge
    int  m_phase, m_code, c_code, a_code, e_code, e_rep, e_hold, cnt;
    bit  m_any, m_mul, c_down, c_mul, a_down, a_mul, e_valid, e_irq;

    always @(posedge clk) begin : model
        int per, prd, r, lowc, np;
        bit done, acc_ok, press, rel, fire;
        cyc++;
        if (rst) begin
            m_phase = 0; m_any = 0; m_mul = 0; m_code = 0;
            c_down = 0; c_mul = 0; c_code = 0; cnt = 0;
            a_down = 0; a_mul = 0; a_code = 0;
            e_valid = 0; e_code = 0; e_rep = 0; e_hold = 0; e_irq = 0;
        end else begin
            per  = int'(cfg_settle) + 2;
            prd  = int'(cfg_rows) * per + 1;
            done = (m_phase == prd - 1);
            acc_ok = (cnt == int'(cfg_debounce)) &&
                     (c_down != a_down || c_mul != a_mul || c_code != a_code);
            press = acc_ok && c_down && (!a_down || c_code != a_code);
            rel   = acc_ok && !c_down && a_down;
            fire  = 0;
            if (press) begin
                fire = 1; e_code = c_code; e_rep = 0; e_hold = 0;
            end else if (rel) begin
                e_rep = 0; e_hold = 0;
            end else if (a_down && cfg_hold_mode) begin
                if (e_hold == int'(cfg_hold_period)) begin
                    e_hold = 0; fire = 1;
                    if (e_rep < 255) e_rep++;
                end else e_hold++;
            end
            e_valid = fire;
            e_irq   = fire || (e_irq && !irq_clear);
            if (acc_ok) begin a_down = c_down; a_mul = c_mul; a_code = c_code; end
            if (done && (m_any != c_down || m_mul != c_mul || m_code != c_code)) begin
                c_down = m_any; c_mul = m_mul; c_code = m_code; cnt = 0;
            end else if (cnt != int'(cfg_debounce)) cnt++;
            if (done) begin
                m_any = 0; m_mul = 0; m_code = 0; m_phase = 0;
            end else begin
                if (m_phase % per == per - 1) begin
                    r = m_phase / per; np = 0; lowc = -1;
                    for (int c = 0; c < int'(cfg_cols); c++)
                        if (keys[r][c]) begin np++; if (lowc < 0) lowc = c; end
                    if (np > 0) begin
                        if (m_any || np > 1) m_mul = 1;
                        if (!m_any) m_code = r * 8 + lowc;
                        m_any = 1;
                    end
                end
                m_phase++;
            end
        end
    end

    // compare design with model on every cycle
    always @(negedge clk) begin : compare
        int a [6];
        int e [6];
        string t [6];
        int per;
        if (cyc >= 2) begin
            per  = int'(cfg_settle) + 2;
            a[0] = int'(row_drv_n);
            e[0] = (m_phase == int'(cfg_rows) * per) ? 255 : (255 ^ (1 << (m_phase / per)));
            t[0] = "R1 row drive";
            a[1] = int'(key_valid);  e[1] = int'(e_valid); t[1] = "R4 key_valid";
            a[2] = int'(key_code);   e[2] = e_code;        t[2] = "R4 key_code";
            a[3] = int'(key_repeat); e[3] = e_rep;         t[3] = "R7 key_repeat";
            a[4] = int'(multi_key);  e[4] = int'(a_mul);   t[4] = "R9 multi_key";
            a[5] = int'(irq);        e[5] = int'(e_irq);   t[5] = "R5 irq";
            for (int i = 0; i < 6; i++) begin
                cmp_n++;
                if (a[i] != e[i]) begin
                    cmp_f++;
                    $display("FAIL %s: actual %0d expected %0d at cycle %0d", t[i], a[i], e[i], cyc);
                end
            end
        end
        if (key_valid) ev_total++;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures",
                     cmp_n + sc_n + 1, cmp_f + sc_f + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        sc_n++;
        if (!ok) begin
            sc_f++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit hold_mode);
        rst = 1'b1;
        cfg_hold_mode = hold_mode;
        wait_n(3);
        rst = 1'b0;
    endtask

    initial begin : stim
        int base;
        for (int r = 0; r < 8; r++) keys[r] = '0;
        wait_n(3);
        // R10: reset state
        chk("R10 row0 in reset", row_drv_n == 8'hFE, int'(row_drv_n), 254);
        chk("R10 outputs in reset", {key_valid, irq, multi_key} == 3'b0 && key_repeat == 0,
            int'({key_valid, irq, multi_key}), 0);
        rst = 1'b0;
        wait_n(40);

        // R3: short closure is filtered
        base = ev_total;
        keys[1][2] = 1'b1; wait_n(5); keys[1][2] = 1'b0; wait_n(100);
        chk("R3 glitch filtered", ev_total == base, ev_total - base, 0);

        // R2: key in a column beyond cfg_cols is ignored
        keys[0][5] = 1'b1; wait_n(150);
        chk("R2 unused column ignored", ev_total == base, ev_total - base, 0);
        chk("R2 no irq", irq == 1'b0, int'(irq), 0);
        keys[0][5] = 1'b0; wait_n(100);

        // R4, R6: press-release-press
        keys[2][1] = 1'b1; wait_n(150);
        chk("R4 one press event", ev_total == base + 1, ev_total - base, 1);
        chk("R4 code row2 col1", key_code == 6'd17, int'(key_code), 17);
        chk("R5 irq pending", irq == 1'b1, int'(irq), 1);
        wait_n(300);
        chk("R6 held key no repeat", ev_total == base + 1, ev_total - base, 1);
        chk("R6 repeat zero", key_repeat == 0, int'(key_repeat), 0);
        keys[2][1] = 1'b0; wait_n(150);
        keys[2][1] = 1'b1; wait_n(150);
        chk("R6 second press", ev_total == base + 2, ev_total - base, 2);
        keys[2][1] = 1'b0; wait_n(150);

        // R5: clear
        irq_clear = 1'b1; wait_n(1); irq_clear = 1'b0; wait_n(1);
        chk("R5 irq cleared", irq == 1'b0, int'(irq), 0);

        // R9: multi-key across rows and within a row
        keys[1][3] = 1'b1; keys[2][0] = 1'b1; wait_n(150);
        chk("R9 multi across rows", multi_key == 1'b1, int'(multi_key), 1);
        chk("R9 lowest row code", key_code == 6'd11, int'(key_code), 11);
        keys[1][3] = 1'b0; keys[2][0] = 1'b0; wait_n(150);
        chk("R9 multi falls on release", multi_key == 1'b0, int'(multi_key), 0);
        keys[3][2] = 1'b1; keys[3][1] = 1'b1; wait_n(150);
        chk("R9 lowest column code", key_code == 6'd25, int'(key_code), 25);
        chk("R9 multi within row", multi_key == 1'b1, int'(multi_key), 1);
        keys[3][2] = 1'b0; keys[3][1] = 1'b0; wait_n(150);

        // R7, R8: press-hold repeat
        do_reset(1'b1);
        keys[3][3] = 1'b1; wait_n(400);
        chk("R7 repeats counted", key_repeat >= 8'd3, int'(key_repeat), 3);
        chk("R7 code kept", key_code == 6'd27, int'(key_code), 27);
        keys[3][3] = 1'b0; wait_n(150);
        chk("R8 repeat cleared", key_repeat == 0, int'(key_repeat), 0);

        // R10: reset while held
        keys[0][0] = 1'b1; wait_n(250);
        chk("R7 repeat before reset", key_repeat != 0, int'(key_repeat), 1);
        rst = 1'b1; wait_n(2);
        chk("R10 repeat reset", key_repeat == 0 && irq == 1'b0 && multi_key == 1'b0,
            int'(key_repeat), 0);
        chk("R10 row0 after reset", row_drv_n == 8'hFE, int'(row_drv_n), 254);
        keys[0][0] = 1'b0;

        // R1, R4: full 8x8 matrix, no settle cycles
        cfg_rows = 4'd8; cfg_cols = 4'd8; cfg_settle = 8'd0; cfg_debounce = 8'd3;
        do_reset(1'b0);
        base = ev_total;
        keys[7][7] = 1'b1; wait_n(100);
        chk("R4 corner code 63", key_code == 6'd63, int'(key_code), 63);
        chk("R4 corner event", ev_total == base + 1, ev_total - base, 1);
        keys[7][7] = 1'b0; wait_n(60);

        $display("End of test - %0d assertions evaluated, %0d failures",
                 cmp_n + sc_n, cmp_f + sc_f);
        $finish;
    end
endmodule